// File: doc/BRIEF.md
# Segmented Auto-Increment Register Map

This block holds the configuration registers behind a slave control port, together with the address pointer that selects among them. It sits below a serial framing layer, which is not part of this block. That layer presents each transferred byte as a one-cycle strobe. A strobe can carry a start-of-transaction flag and a direction bit. Write data goes in on a byte bus, and the byte at the pointer comes back out on a read bus. The port may run with no relation to the audio sample rate.

The first written byte of a transaction is the map byte. Its top bit enables auto-increment and its lower seven bits give the pointer. Each later byte writes the pointed register, or reads it, and then the pointer may advance. Advancing is confined to two disjoint windows: 0x01 through 0x08, and 0x09 through 0x11. At the last address of either window the pointer parks. It never runs from the first window into the second. Addresses outside both windows hold no storage.

Top module: `cp_regmap`

## Requirements
- R1: A strobe with the start flag and the write direction is a map byte. Bits 6:0 load the pointer, bit 7 loads the increment enable (1 = advance), and no register is written.
- R2: With the increment enable at 0, the pointer keeps its value across any number of read or write data bytes.
- R3: With the increment enable at 1 and the pointer in 0x01..0x07, each data byte moves the pointer up by one.
- R4: With the increment enable at 1 and the pointer in 0x09..0x10, each data byte moves the pointer up by one.
- R5: At 0x08 the pointer holds after a data byte, so a burst that starts in the low window never reaches 0x09.
- R6: At 0x11 the pointer holds after a data byte, so further bytes keep landing on 0x11.
- R7: Addresses 0x00 and 0x12..0x7F are unmapped. Writes there change nothing, reads return 0x00, and the pointer does not advance from them.
- R8: On reset the pointer is 0x00, the increment enable is 0, and each mapped register at address a holds a XOR 0xA0.
- R9: A write data byte (direction 1, no start) stores its data in the pointed mapped register. The read bus shows the pointed register's contents at all times, and it follows a pointer change from the next cycle.
- R10: A strobe with the start flag and the read direction does not load the pointer. It reads at the pointer kept from earlier transactions, and it advances the pointer like any other data byte.
- R11: Cycles with the byte valid low change neither the pointer nor any register, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Control-port clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cp_start | input | 1 | Byte is the first of a transaction |
| cp_valid | input | 1 | One-cycle byte strobe |
| cp_write | input | 1 | 1 = byte written into the block, 0 = byte read out |
| cp_wdata | input | 8 | Map byte or register write data |
| cp_rdata | output | 8 | Contents of the pointed register, 0 when unmapped |

## Verification
The assertions assume that every byte is a single-cycle strobe of cp_valid. They also assume that the control inputs are at defined levels on each rising edge. The pointer rules are stated per strobe, so a held strobe would count as several bytes. The bench therefore drives each byte on a falling edge and drops it after one rising edge. It puts random-looking data on the inputs only while the strobe is low.

// File: rtl/cp_regmap_pkg.sv
package cp_regmap_pkg;

    typedef enum logic [1:0] {
        SEG_NONE = 2'd0,
        SEG_LOW  = 2'd1,
        SEG_HIGH = 2'd2
    } seg_t;

    // Power-on contents of the register at a given address
    function automatic logic [31:0] regmap_default(input int unsigned addr);
        return 32'(addr) ^ 32'h0000_00A0;
    endfunction

endpackage

// File: rtl/cp_seg_decode.sv
module cp_seg_decode
    import cp_regmap_pkg::*;
#(
    parameter int ADDR_W   = 7,
    parameter int SEG_A_LO = 1,
    parameter int SEG_A_HI = 8,
    parameter int SEG_B_LO = 9,
    parameter int SEG_B_HI = 17
) (
    input  logic [ADDR_W-1:0] addr,
    output seg_t              seg,
    output logic              at_end
);
    localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(SEG_A_LO);
    localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(SEG_A_HI);
    localparam logic [ADDR_W-1:0] B_LO = ADDR_W'(SEG_B_LO);
    localparam logic [ADDR_W-1:0] B_HI = ADDR_W'(SEG_B_HI);

    always_comb begin
        seg = SEG_NONE;
        if (addr >= A_LO && addr <= A_HI) begin
            seg = SEG_LOW;
        end else if (addr >= B_LO && addr <= B_HI) begin
            seg = SEG_HIGH;
        end
        at_end = (addr == A_HI) || (addr == B_HI);
    end

endmodule

// File: rtl/cp_ptr_ctrl.sv
module cp_ptr_ctrl
    import cp_regmap_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = DATA_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [DATA_W-1:0] load_val,
    input  seg_t              seg,
    input  logic              at_end,
    output logic [ADDR_W-1:0] ptr,
    output logic              incr
);
    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
        logic              incr;
    } ptr_state_t;

    ptr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.ptr  = load_val[ADDR_W-1:0];
            st_d.incr = load_val[DATA_W-1];
        end else if (step && st_q.incr && seg != SEG_NONE && !at_end) begin
            st_d.ptr = st_q.ptr + ADDR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr  = st_q.ptr;
    assign incr = st_q.incr;

endmodule

// File: rtl/cp_regfile.sv
module cp_regfile
    import cp_regmap_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 7,
    parameter int SPAN_LO  = 1,
    parameter int SPAN_HI  = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] ptr,
    input  seg_t              seg,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int NREG  = SPAN_HI - SPAN_LO + 1;
    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;
    localparam logic [ADDR_W-1:0] LO_V = ADDR_W'(SPAN_LO);

    typedef struct packed {
        logic [NREG-1:0][DATA_W-1:0] regs;
    } rf_state_t;

    rf_state_t        st_d, st_q;
    logic [IDX_W-1:0] idx;
    logic             mapped;

    assign idx    = IDX_W'(ptr - LO_V);
    assign mapped = (seg != SEG_NONE);

    always_comb begin
        st_d = st_q;
        if (we && mapped) begin
            st_d.regs[idx] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                st_q.regs[i] <= DATA_W'(regmap_default(SPAN_LO + i));
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = mapped ? st_q.regs[idx] : '0;

endmodule

// File: rtl/cp_regmap.sv
module cp_regmap
    import cp_regmap_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int SEG_A_LO = 1,
    parameter int SEG_A_HI = 8,
    parameter int SEG_B_LO = 9,
    parameter int SEG_B_HI = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cp_start,
    input  logic              cp_valid,
    input  logic              cp_write,
    input  logic [DATA_W-1:0] cp_wdata,
    output logic [DATA_W-1:0] cp_rdata
);
    localparam int ADDR_W = DATA_W - 1;

    logic              is_map_byte;
    logic              is_data_byte;
    logic              data_we;
    logic [ADDR_W-1:0] map_ptr;
    logic              map_incr;
    seg_t              ptr_seg;
    logic              ptr_at_end;

    assign is_map_byte  = cp_valid && cp_start && cp_write;
    assign is_data_byte = cp_valid && !is_map_byte;
    assign data_we      = is_data_byte && cp_write;

    cp_seg_decode #(
        .ADDR_W  (ADDR_W),
        .SEG_A_LO(SEG_A_LO),
        .SEG_A_HI(SEG_A_HI),
        .SEG_B_LO(SEG_B_LO),
        .SEG_B_HI(SEG_B_HI)
    ) u_decode (
        .addr  (map_ptr),
        .seg   (ptr_seg),
        .at_end(ptr_at_end)
    );

    cp_ptr_ctrl #(
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W)
    ) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (is_map_byte),
        .step    (is_data_byte),
        .load_val(cp_wdata),
        .seg     (ptr_seg),
        .at_end  (ptr_at_end),
        .ptr     (map_ptr),
        .incr    (map_incr)
    );

    cp_regfile #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .SPAN_LO(SEG_A_LO),
        .SPAN_HI(SEG_B_HI)
    ) u_regs (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (data_we),
        .ptr  (map_ptr),
        .seg  (ptr_seg),
        .wdata(cp_wdata),
        .rdata(cp_rdata)
    );

endmodule

// File: rtl/cp_regmap_chk.sv
module cp_regmap_chk #(
    parameter int DATA_W   = 8,
    parameter int SEG_A_LO = 1,
    parameter int SEG_A_HI = 8,
    parameter int SEG_B_LO = 9,
    parameter int SEG_B_HI = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cp_start,
    input logic              cp_valid,
    input logic              cp_write,
    input logic [DATA_W-1:0] cp_wdata,
    input logic [DATA_W-1:0] cp_rdata,
    input logic [DATA_W-2:0] map_ptr,
    input logic              map_incr
);
    localparam int ADDR_W = DATA_W - 1;
    localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(SEG_A_LO);
    localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(SEG_A_HI);
    localparam logic [ADDR_W-1:0] B_LO = ADDR_W'(SEG_B_LO);
    localparam logic [ADDR_W-1:0] B_HI = ADDR_W'(SEG_B_HI);

    logic map_byte, data_byte, unmapped;
    assign map_byte  = cp_valid && cp_start && cp_write;
    assign data_byte = cp_valid && !map_byte;
    assign unmapped  = (map_ptr < A_LO) || (map_ptr > B_HI) ||
                       (map_ptr > A_HI && map_ptr < B_LO);

    AST_MAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        map_byte |=> (map_ptr == $past(cp_wdata[ADDR_W-1:0]) &&
                      map_incr == $past(cp_wdata[DATA_W-1]))); // R1

    AST_FIXED_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (data_byte && !map_incr) |=> $stable(map_ptr)); // R2

    AST_LOW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (data_byte && map_incr && map_ptr >= A_LO && map_ptr < A_HI)
        |=> map_ptr == ADDR_W'($past(map_ptr) + ADDR_W'(1))); // R3

    AST_HIGH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (data_byte && map_incr && map_ptr >= B_LO && map_ptr < B_HI)
        |=> map_ptr == ADDR_W'($past(map_ptr) + ADDR_W'(1))); // R4

    AST_NO_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
        (data_byte && map_ptr == A_HI) |=> map_ptr == A_HI); // R5

    AST_HIGH_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        (data_byte && map_ptr == B_HI) |=> map_ptr == B_HI); // R6

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped |-> cp_rdata == '0); // R7

    AST_UNMAPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (data_byte && unmapped) |=> $stable(map_ptr)); // R7

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cp_valid |=> ($stable(map_ptr) && $stable(map_incr) && $stable(cp_rdata))); // R11

endmodule

bind cp_regmap cp_regmap_chk #(
    .DATA_W  (DATA_W),
    .SEG_A_LO(SEG_A_LO),
    .SEG_A_HI(SEG_A_HI),
    .SEG_B_LO(SEG_B_LO),
    .SEG_B_HI(SEG_B_HI)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cp_start(cp_start),
    .cp_valid(cp_valid),
    .cp_write(cp_write),
    .cp_wdata(cp_wdata),
    .cp_rdata(cp_rdata),
    .map_ptr (map_ptr),
    .map_incr(map_incr)
);

// File: tb/cp_regmap_tb.sv
`timescale 1ns/1ps
module cp_regmap_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cp_start = 1'b0;
    logic       cp_valid = 1'b0;
    logic       cp_write = 1'b0;
    logic [7:0] cp_wdata = 8'h00;
    logic [7:0] cp_rdata;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    cp_regmap u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .cp_start(cp_start),
        .cp_valid(cp_valid),
        .cp_write(cp_write),
        .cp_wdata(cp_wdata),
        .cp_rdata(cp_rdata)
    );

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    // One byte strobe; rd is the read bus seen while the strobe is up
    task automatic xfer(input logic st, input logic wr, input logic [7:0] d,
                        output logic [7:0] rd);
        @(negedge clk);
        cp_start = st; cp_valid = 1'b1; cp_write = wr; cp_wdata = d;
        #1 rd = cp_rdata;
        @(posedge clk);
        #1;
        cp_start = 1'b0; cp_valid = 1'b0; cp_write = 1'b0; cp_wdata = 8'h00;
    endtask

    task automatic map_byte(input logic [7:0] m);
        logic [7:0] rd;
        xfer(1'b1, 1'b1, m, rd);
    endtask

    task automatic wr_byte(input logic [7:0] d);
        logic [7:0] rd;
        xfer(1'b0, 1'b1, d, rd);
    endtask

    task automatic rd_expect(input string req, input logic [7:0] exp);
        logic [7:0] rd;
        xfer(1'b0, 1'b0, 8'h00, rd);
        check8(req, rd, exp);
    endtask

    task automatic read_at(input string req, input logic [6:0] a, input logic [7:0] exp);
        map_byte({1'b0, a});
        rd_expect(req, exp);
    endtask

    task automatic t_reset_defaults();
        @(negedge clk);
        check8("R8 pointer at 0 reads zero", cp_rdata, 8'h00);
        for (int a = 0; a < 20; a++) begin
            if (a >= 1 && a <= 17)
                read_at("R8 default", 7'(a), 8'(a) ^ 8'hA0);
            else
                read_at("R7 unmapped default", 7'(a), 8'h00);
        end
    endtask

    task automatic t_low_burst();
        map_byte(8'h81);
        for (int i = 0; i < 10; i++) wr_byte(8'h10 + 8'(i));
        map_byte(8'h81);
        for (int i = 0; i < 7; i++) rd_expect("R3 R9 low burst readback", 8'h10 + 8'(i));
        rd_expect("R5 last of low window", 8'h19);
        rd_expect("R5 parked at 0x08", 8'h19);
        read_at("R5 0x09 untouched", 7'h09, 8'hA9);
    endtask

    task automatic t_high_burst();
        map_byte(8'h8F);
        wr_byte(8'h31); wr_byte(8'h32); wr_byte(8'h33); wr_byte(8'h34);
        map_byte(8'h8F);
        rd_expect("R4 high 0x0F", 8'h31);
        rd_expect("R4 high 0x10", 8'h32);
        rd_expect("R6 high 0x11", 8'h34);
        rd_expect("R6 parked at 0x11", 8'h34);
    endtask

    task automatic t_fixed_ptr();
        map_byte(8'h05);
        wr_byte(8'hC1); wr_byte(8'hC2); wr_byte(8'hC3);
        read_at("R2 neighbour untouched", 7'h06, 8'h15);
        map_byte(8'h05);
        rd_expect("R2 fixed read 1", 8'hC3);
        rd_expect("R2 fixed read 2", 8'hC3);
        rd_expect("R2 fixed read 3", 8'hC3);
    endtask

    task automatic t_unmapped();
        map_byte(8'h80);
        wr_byte(8'h77); wr_byte(8'h78);
        map_byte(8'h92);
        wr_byte(8'h55);
        map_byte(8'h80);
        rd_expect("R7 read 0x00", 8'h00);
        rd_expect("R7 pointer held at 0x00", 8'h00);
        read_at("R7 read 0x12", 7'h12, 8'h00);
        read_at("R7 0x01 not disturbed", 7'h01, 8'h10);
        read_at("R7 0x11 not disturbed", 7'h11, 8'h34);
    endtask

    task automatic t_read_start();
        logic [7:0] rd;
        map_byte(8'h83);
        xfer(1'b1, 1'b0, 8'h7E, rd);
        check8("R10 start read at kept pointer", rd, 8'h12);
        rd_expect("R10 advanced after start read", 8'h13);
        xfer(1'b1, 1'b0, 8'h01, rd);
        check8("R10 second start read", rd, 8'hC3);
    endtask

    task automatic t_idle();
        map_byte(8'h82);
        @(negedge clk);
        cp_start = 1'b1; cp_write = 1'b1; cp_wdata = 8'h0A;
        repeat (3) @(negedge clk);
        check8("R11 read bus unchanged while idle", cp_rdata, 8'h11);
        cp_start = 1'b0; cp_write = 1'b0; cp_wdata = 8'h00;
        rd_expect("R11 pointer not reloaded", 8'h11);
        rd_expect("R11 increment kept", 8'h12);
    endtask

    initial begin
        #(8 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset_defaults();
        t_low_burst();
        t_high_burst();
        t_fixed_ptr();
        t_unmapped();
        t_read_start();
        t_idle();
        repeat (2) @(posedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule